// File: doc/BRIEF.md
# Stream-to-Memory Write Engine

This block drains a valid/ready stream of data beats into memory, acting as a master on a pipelined Wishbone bus. Each beat carries one data word, a count of valid bytes and an end marker. A one-cycle request starts a transfer. At that moment the block latches a byte base address, a flag that selects an advancing or a fixed address, and a 2-bit width code. Every accepted beat becomes exactly one bus write. The transfer ends with the beat that carries the end marker.

Writes can be the full bus width, 32-bit, 16-bit or 8-bit. Byte lanes are little-endian. For the narrower widths, the low bytes of the beat are steered to the lanes that the current byte address selects, and the matching select bits are raised. The block keeps a count of writes that are still waiting for a response. It holds the bus cycle open until every write has been answered, and it records any error response in a sticky flag.

Top module: `s2mm_writer`

## Requirements
- R1: A request is taken only while busy is low. It latches base address, advance flag and width code, and busy is high from the next cycle. A request while busy changes nothing.
- R2: Width code 00 writes the full bus width, 01 writes 4 bytes, 10 writes 2 bytes and 11 writes 1 byte. For the narrow widths the data lanes hold the low bytes of the beat.
- R3: The word address is the byte address shifted right by log2(bus bytes). With the advance flag at 1, the byte address grows by the write size in bytes (the bus byte count for code 00) after each beat. With the flag at 0, it stays at the base.
- R4: For the narrow widths, the lowest selected lane is the byte offset inside the word, rounded down to a multiple of the write size. The selected lanes are that one and the ones directly above it, as many as the write size. Unselected data lanes are zero.
- R5: For full-width writes with a byte count of k in 1..NB, select bits 0..k-1 are set. A count of 0 or more than NB sets every select bit. Select is never all-zero.
- R6: While stb is high and stall is high, the next cycle keeps stb high and address, data and select unchanged. A write counts as issued only on a cycle with stb high and stall low.
- R7: Each accepted beat produces exactly one write. After the beat with the end marker, ready stays low until a new request.
- R8: Busy and cyc fall only after every issued write has had an ack or error response. While idle, stb and ready are low.
- R9: An error response sets the error flag. It stays set through idle cycles and clears only on reset or an accepted request.
- R10: After reset, busy, error, cyc, stb and ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | One-cycle start request |
| req_base_i | input | ADDR_W | Byte base address |
| req_inc_i | input | 1 | 1 = advance the address, 0 = fixed address |
| req_size_i | input | 2 | Width code |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Sticky bus error flag |
| s_valid_i | input | 1 | Stream beat valid |
| s_ready_o | output | 1 | Stream beat accepted |
| s_data_i | input | DATA_W | Beat data |
| s_bytes_i | input | CNT_W | Valid byte count (full-width writes) |
| s_last_i | input | 1 | Final beat marker |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W-log2(DATA_W/8) | Word address |
| wb_dat_o | output | DATA_W | Write data |
| wb_sel_o | output | DATA_W/8 | Byte lane select |
| wb_stall_i | input | 1 | Slave stall |
| wb_ack_i | input | 1 | Write acknowledge |
| wb_err_i | input | 1 | Error response |

## Verification
A wrong address register would show on the very first write after a misaligned base or a width change. The errors are a shifted word address, select bits in the wrong lanes, or a second write landing on the wrong address. A wrong outstanding count would show only at the end of a transfer, because busy would fall while responses are still due, or cyc would stay open forever. That is why the bench pulls responses back against heavy random stall. A lost latch of the request settings would show on the first issued write, because the bench scrambles those inputs one cycle after the request.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;

    typedef enum logic [1:0] {
        SZ_BUS = 2'b00,
        SZ_W32 = 2'b01,
        SZ_W16 = 2'b10,
        SZ_W8  = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic       inc;
        xfer_size_e size;
    } xfer_cfg_t;

    // bytes written per beat for a width code on a bus of nb bytes
    function automatic int size_bytes(input xfer_size_e sz, input int nb);
        case (sz)
            SZ_W32:  return 4;
            SZ_W16:  return 2;
            SZ_W8:   return 1;
            default: return nb;
        endcase
    endfunction

endpackage

// File: rtl/s2mm_lane_steer.sv
module s2mm_lane_steer
    import s2mm_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int NB    = DATA_W / 8,
    localparam int LSB_W = $clog2(NB),
    localparam int CNT_W = $clog2(NB + 1)
) (
    input  xfer_size_e        size_i,
    input  logic [LSB_W-1:0]  off_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CNT_W-1:0]  nbytes_i,
    output logic [DATA_W-1:0] data_o,
    output logic [NB-1:0]     sel_o
);

    logic full;
    int   wbytes;
    int   low_lane;

    always_comb begin
        full     = (size_i == SZ_BUS);
        wbytes   = size_bytes(size_i, NB);
        low_lane = full ? 0 : (int'(off_i) & ~(wbytes - 1));
    end

    for (genvar j = 0; j < NB; j++) begin : g_lane
        always_comb begin
            logic hit;
            int   src;
            if (full) begin
                hit = (nbytes_i == '0) || (j < int'(nbytes_i)) || (int'(nbytes_i) > NB);
                src = j;
            end else begin
                hit = (j >= low_lane) && (j < low_lane + wbytes);
                src = hit ? (j - low_lane) : 0;
            end
            sel_o[j]          = hit;
            data_o[j*8 +: 8]  = (full || hit) ? data_i[src*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/s2mm_addr_gen.sv
module s2mm_addr_gen
    import s2mm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NB     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  xfer_cfg_t         cfg_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] stride;
    assign stride = ADDR_W'(size_bytes(cfg_i.size, NB));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
        end else if (load_i) begin
            addr_o <= base_i;
        end else if (step_i && cfg_i.inc) begin
            addr_o <= addr_o + stride;
        end
    end

endmodule

// File: rtl/s2mm_resp_track.sv
module s2mm_resp_track #(
    parameter int OUT_W  = 4,
    localparam int LIMIT = (1 << OUT_W) - 1
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    input  logic resp_i,
    output logic empty_o,
    output logic near_full_o
);

    logic [OUT_W-1:0] pend_q;
    logic             resp_ok;

    assign resp_ok = resp_i && (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            case ({issue_i, resp_ok})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign empty_o     = (pend_q == '0);
    assign near_full_o = (pend_q >= OUT_W'(LIMIT - 1));

endmodule

// File: rtl/s2mm_writer.sv
module s2mm_writer
    import s2mm_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 32,
    parameter int OUT_W   = 4,
    localparam int NB     = DATA_W / 8,
    localparam int LSB_W  = $clog2(NB),
    localparam int CNT_W  = $clog2(NB + 1),
    localparam int WADR_W = ADDR_W - LSB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_base_i,
    input  logic              req_inc_i,
    input  logic [1:0]        req_size_i,
    output logic              busy_o,
    output logic              err_o,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [DATA_W-1:0] s_data_i,
    input  logic [CNT_W-1:0]  s_bytes_i,
    input  logic              s_last_i,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [WADR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    output logic [NB-1:0]     wb_sel_o,
    input  logic              wb_stall_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);

    wr_state_e         state_q;
    xfer_cfg_t         cfg_q;
    logic              err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] lane_data;
    logic [NB-1:0]     lane_sel;

    logic              stb_q;
    logic [WADR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic [NB-1:0]     sel_q;

    logic start, take, issue, resp, trk_empty, trk_near;

    assign start     = req_i && (state_q == ST_IDLE);
    assign issue     = stb_q && !wb_stall_i;
    assign s_ready_o = (state_q == ST_RUN) && (!stb_q || !wb_stall_i) && !trk_near;
    assign take      = s_valid_i && s_ready_o;
    assign resp      = (wb_ack_i || wb_err_i) && (state_q != ST_IDLE);

    // transfer sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start) state_q <= ST_RUN;
                ST_RUN:   if (take && s_last_i) state_q <= ST_DRAIN;
                ST_DRAIN: if (!stb_q && trk_empty) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // settings latched at the request
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{inc: 1'b1, size: SZ_BUS};
        end else if (start) begin
            cfg_q <= '{inc: req_inc_i, size: xfer_size_e'(req_size_i)};
        end
    end

    // sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (start) begin
            err_q <= 1'b0;
        end else if (wb_err_i && (state_q != ST_IDLE)) begin
            err_q <= 1'b1;
        end
    end

    // single-entry request stage, held while stalled
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q <= 1'b0;
            adr_q <= '0;
            dat_q <= '0;
            sel_q <= '0;
        end else if (take) begin
            stb_q <= 1'b1;
            adr_q <= addr_q[ADDR_W-1:LSB_W];
            dat_q <= lane_data;
            sel_q <= lane_sel;
        end else if (issue) begin
            stb_q <= 1'b0;
        end
    end

    s2mm_addr_gen #(
        .ADDR_W (ADDR_W),
        .NB     (NB)
    ) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load_i (start),
        .base_i (req_base_i),
        .cfg_i  (cfg_q),
        .step_i (take),
        .addr_o (addr_q)
    );

    s2mm_lane_steer #(
        .DATA_W (DATA_W)
    ) u_steer (
        .size_i   (cfg_q.size),
        .off_i    (addr_q[LSB_W-1:0]),
        .data_i   (s_data_i),
        .nbytes_i (s_bytes_i),
        .data_o   (lane_data),
        .sel_o    (lane_sel)
    );

    s2mm_resp_track #(
        .OUT_W (OUT_W)
    ) u_track (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (issue),
        .resp_i      (resp),
        .empty_o     (trk_empty),
        .near_full_o (trk_near)
    );

    assign busy_o   = (state_q != ST_IDLE);
    assign err_o    = err_q;
    assign wb_cyc_o = (state_q != ST_IDLE);
    assign wb_stb_o = stb_q;
    assign wb_we_o  = 1'b1;
    assign wb_adr_o = adr_q;
    assign wb_dat_o = dat_q;
    assign wb_sel_o = sel_q;

endmodule

// File: rtl/s2mm_writer_chk.sv
module s2mm_writer_chk #(
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 32,
    localparam int NB     = DATA_W / 8,
    localparam int WADR_W = ADDR_W - $clog2(NB)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              busy_o,
    input logic              err_o,
    input logic              s_ready_o,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic [WADR_W-1:0] wb_adr_o,
    input logic [DATA_W-1:0] wb_dat_o,
    input logic [NB-1:0]     wb_sel_o,
    input logic              wb_stall_i,
    input logic              cfg_inc,
    input logic [1:0]        cfg_size
);

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_i && !busy_o |=> busy_o); // R1

    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        req_i && busy_o |=> $stable(cfg_inc) && $stable(cfg_size)); // R1

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o && cfg_size == 2'b11 |-> $countones(wb_sel_o) == 1); // R2

    AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o && cfg_size == 2'b10 |-> $countones(wb_sel_o) == 2); // R4

    AST_SEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o |-> wb_sel_o != '0); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o && wb_stall_i |=> wb_stb_o && $stable(wb_adr_o)
            && $stable(wb_dat_o) && $stable(wb_sel_o)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !wb_stb_o && !s_ready_o && !wb_cyc_o); // R8

    AST_STB_IN_CYC: assert property (@(posedge clk) disable iff (rst)
        wb_stb_o |-> wb_cyc_o); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_o && !(req_i && !busy_o) |=> err_o); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        req_i && !busy_o |=> !err_o); // R9

endmodule

bind s2mm_writer s2mm_writer_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .busy_o     (busy_o),
    .err_o      (err_o),
    .s_ready_o  (s_ready_o),
    .wb_cyc_o   (wb_cyc_o),
    .wb_stb_o   (wb_stb_o),
    .wb_adr_o   (wb_adr_o),
    .wb_dat_o   (wb_dat_o),
    .wb_sel_o   (wb_sel_o),
    .wb_stall_i (wb_stall_i),
    .cfg_inc    (cfg_q.inc),
    .cfg_size   (cfg_q.size)
);

// File: tb/s2mm_writer_tb.sv
module s2mm_writer_tb;

    localparam int DATA_W = 64;
    localparam int ADDR_W = 32;
    localparam int NB     = 8;
    localparam int LSB_W  = 3;
    localparam int CNT_W  = 4;
    localparam int WADR_W = ADDR_W - LSB_W;
    localparam int MAXB   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] req_base = '0;
    logic              req_inc = 1'b0;
    logic [1:0]        req_size = 2'b00;
    logic              busy, err, s_ready;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic [CNT_W-1:0]  s_bytes = '0;
    logic              s_last = 1'b0;
    logic              cyc, stb, we;
    logic [WADR_W-1:0] adr;
    logic [DATA_W-1:0] dat;
    logic [NB-1:0]     sel;
    logic              stall = 1'b0;
    logic              ack = 1'b0;
    logic              werr = 1'b0;

    s2mm_writer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_W(4)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .req_base_i(req_base),
        .req_inc_i(req_inc), .req_size_i(req_size), .busy_o(busy), .err_o(err),
        .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
        .s_bytes_i(s_bytes), .s_last_i(s_last), .wb_cyc_o(cyc), .wb_stb_o(stb),
        .wb_we_o(we), .wb_adr_o(adr), .wb_dat_o(dat), .wb_sel_o(sel),
        .wb_stall_i(stall), .wb_ack_i(ack), .wb_err_i(werr)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    logic [DATA_W-1:0] bd [MAXB];
    logic [CNT_W-1:0]  bb [MAXB];
    logic [WADR_W-1:0] la [MAXB];
    logic [DATA_W-1:0] ld [MAXB];
    logic [NB-1:0]     ls [MAXB];
    int                nwr;

    function automatic int szb(input logic [1:0] sz);
        case (sz)
            2'b01:   return 4;
            2'b10:   return 2;
            2'b11:   return 1;
            default: return NB;
        endcase
    endfunction

    task automatic exp_wr(input int i, input logic [ADDR_W-1:0] base, input bit inc,
                          input logic [1:0] sz, output logic [WADR_W-1:0] ea,
                          output logic [DATA_W-1:0] ed, output logic [NB-1:0] es);
        int sb = szb(sz);
        logic [ADDR_W-1:0] ba = inc ? base + ADDR_W'(i * sb) : base;
        int off = (sz == 2'b00) ? 0 : (int'(ba[LSB_W-1:0]) & ~(sb - 1));
        ea = ba[ADDR_W-1:LSB_W];
        ed = '0;
        es = '0;
        for (int j = 0; j < NB; j++) begin
            if (sz == 2'b00) begin
                es[j] = (bb[i] == 0) || (j < int'(bb[i])) || (int'(bb[i]) > NB);
                ed[j*8 +: 8] = bd[i][j*8 +: 8];
            end else if (j >= off && j < off + sb) begin
                es[j] = 1'b1;
                ed[j*8 +: 8] = bd[i][(j-off)*8 +: 8];
            end
        end
    endtask

    task automatic run_xfer(input logic [ADDR_W-1:0] base, input bit inc,
                            input logic [1:0] sz, input int n, input int stall_pct,
                            input int err_at, input bit poke);
        int bi = 0, pend = 0, resp = 0, cy;
        bit held = 0;
        logic [WADR_W-1:0] pa, ea;
        logic [DATA_W-1:0] pd, ed;
        logic [NB-1:0]     ps, es;
        string rq;
        for (int i = 0; i < n; i++) begin
            bd[i] = {$urandom, $urandom};
            bb[i] = CNT_W'($urandom_range(0, NB + 1));
        end
        nwr = 0;
        @(negedge clk);
        req = 1; req_base = base; req_inc = inc; req_size = sz;
        @(negedge clk);
        req = 0; req_base = ~base; req_inc = ~inc; req_size = ~sz;
        #1;
        chk(busy == 1'b1, "R1", "busy after request", 64'(busy), 64'd1);
        chk(err == 1'b0, "R9", "error cleared by request", 64'(err), 64'd0);
        for (cy = 0; cy < 5000; cy++) begin
            if (cy > 0) @(negedge clk);
            stall = ($urandom_range(0, 99) < stall_pct);
            ack = 0; werr = 0;
            if (pend > 0 && $urandom_range(0, 2) != 0) begin
                if (resp == err_at) werr = 1; else ack = 1;
                resp++; pend--;
            end
            req = poke && (cy == 3);
            req_base = base + 32'h400;
            req_size = ~sz;
            s_valid = (bi < n) && ($urandom_range(0, 3) != 0);
            s_data  = bd[(bi < n) ? bi : 0];
            s_bytes = bb[(bi < n) ? bi : 0];
            s_last  = (bi == n - 1);
            #1;
            if (held)
                chk(stb && adr == pa && dat == pd && sel == ps, "R6",
                    "payload held under stall", {35'd0, adr}, {35'd0, pa});
            held = stb && stall;
            pa = adr; pd = dat; ps = sel;
            if (stb && !stall) begin
                if (nwr < MAXB) begin la[nwr] = adr; ld[nwr] = dat; ls[nwr] = sel; end
                nwr++; pend++;
            end
            if (s_valid && s_ready) bi++;
            if (!busy) begin
                chk(pend == 0, "R8", "busy fell with writes outstanding", 64'(pend), 64'd0);
                break;
            end
        end
        chk(cy < 5000, "R8", "transfer finished", 64'(cy), 64'd0);
        @(negedge clk);
        s_valid = 1; s_last = 0; stall = 0; ack = 0; werr = 0; req = 0;
        #1;
        chk(s_ready == 1'b0, "R7", "ready low after final beat", 64'(s_ready), 64'd0);
        s_valid = 0;
        chk(nwr == n, "R7", "one write per beat", 64'(nwr), 64'(n));
        for (int i = 0; i < n && i < nwr; i++) begin
            exp_wr(i, base, inc, sz, ea, ed, es);
            chk(la[i] == ea, "R3", "word address", {35'd0, la[i]}, {35'd0, ea});
            rq = (sz == 2'b00) ? "R5" : "R4";
            chk(ls[i] == es, rq, "byte select", 64'(ls[i]), 64'(es));
            for (int j = 0; j < NB; j++)
                if (es[j] && ls[i][j])
                    chk(ld[i][j*8 +: 8] == ed[j*8 +: 8], "R2", "lane data",
                        64'(ld[i][j*8 +: 8]), 64'(ed[j*8 +: 8]));
        end
        chk(err == (err_at >= 0 && err_at < n), "R9", "error flag at end",
            64'(err), 64'(err_at >= 0 && err_at < n));
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !err && !cyc && !stb && !s_ready, "R10", "reset state",
            {59'd0, busy, err, cyc, stb, s_ready}, 64'd0);
        rst = 0;
        // directed corners
        run_xfer(32'h0000_1000, 1, 2'b00, 8, 0, -1, 0);
        run_xfer(32'h0000_2004, 1, 2'b01, 9, 30, -1, 0);
        run_xfer(32'h0000_3001, 1, 2'b10, 10, 50, -1, 0);
        run_xfer(32'h0000_4005, 0, 2'b11, 6, 20, -1, 0);
        run_xfer(32'h0000_5008, 0, 2'b00, 5, 60, -1, 0);
        run_xfer(32'h0000_6003, 1, 2'b11, 1, 0, -1, 0);
        run_xfer(32'h0000_7000, 1, 2'b01, 12, 40, -1, 1);
        run_xfer(32'h0000_8000, 1, 2'b00, 7, 30, 2, 0);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R9", "error stays set while idle", 64'(err), 64'd1);
        // random mix
        for (int t = 0; t < 24; t++)
            run_xfer($urandom, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
                     $urandom_range(1, 40), $urandom_range(0, 80),
                     ($urandom_range(0, 3) == 0) ? $urandom_range(0, 10) : -1,
                     1'($urandom_range(0, 1)));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5ns * 190000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule